// File: doc/BRIEF.md
# One-Time-Programmable Fuse Sequencer

This block sits between a simple register bus and a one-time-programmable fuse array. Software loads a fuse address, a timing set and an unlock key into registers. It then starts either a program cycle, which burns a data word into the addressed fuse word, or a sense cycle, which reads the word back from the array into a result register. Every operation is timed in bus clock cycles: a relax interval, then a strobe whose width depends on the operation, then a second relax interval. A busy flag stays high for the whole sequence.

The fuse array is modelled inside the block as a bank of 32-bit words. Programming can only turn bits on. A sticky error flag records every refused request: a program attempt without the key, or any request made while an operation is running. Software clears the flag through a clear-alias register. A set-alias and a clear-alias register change chosen bits of the control register without a read-modify-write.

Top module: `fuse_sequencer`

## Requirements
- R1: After reset the control register reads 0, the timing register reads 0x0004_1008, and the read-data register reads 0. Register byte offsets are: control 0x00, set alias 0x04, clear alias 0x08, timing 0x10, program data 0x20, sense request 0x30, sense result 0x40. Any other offset reads 0.
- R2: The control register holds the unlock field in bits 31:16, the error flag in bit 9, the read-only busy flag in bit 8 and the fuse address in bits 4:0. The address is bank*8+word. A direct write changes only the unlock and address fields. The set and clear aliases read back the control value.
- R3: The timing register holds the program strobe width in bits 11:0, the relax count in bits 15:12 and the sense strobe width in bits 21:16. Busy rises at the clock edge that accepts a request and stays high for exactly 2*(relax+1)+strobe cycles, where strobe is the width for that operation (0 allowed).
- R4: A write to the program data register while the unlock field is not 0x3E77 sets the error flag and starts nothing.
- R5: A write to the program data register while the unlock field is 0x3E77 and busy is low starts a program cycle of the addressed word. The data register reads back the accepted word.
- R6: The unlock field reads 0 after every program cycle completes.
- R7: Writing a value with bit 0 set to the sense request register starts a sense cycle. When busy falls, the result register holds the addressed fuse word. A write with bit 0 clear has no effect. The sense request register reads 0.
- R8: A program cycle ORs the data word into the stored fuse word, so a bit that is already set stays set.
- R9: A program or sense request made while busy is high sets the error flag and is otherwise ignored. This includes the cycle in which busy falls.
- R10: A write to the set alias ORs its bits 31:16, 9 and 4:0 into the control register. A write to the clear alias clears those same bits wherever it holds a 1. The error flag keeps its value against direct control writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrite | input | 1 | Write strobe for the current bus cycle |
| busAddr | input | 8 | Register byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |

## Verification
Program cycles are run with key present, key absent and key written but then overwritten. Each result is shown by the error flag and by a later sense of the same word. Two programs of the same word with overlapping and disjoint bit patterns separate an OR-merge from a plain overwrite. Timing is tried at zero relax with zero strobe, at the reset defaults and at the largest relax with the largest sense strobe. Comparing busy on every cycle catches an off-by-one in any phase. Requests placed in the middle of a sequence and on its final cycle check that refusal covers the whole busy window.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;
  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_SET    = 8'h04;
  localparam logic [7:0] OFS_CLR    = 8'h08;
  localparam logic [7:0] OFS_TIMING = 8'h10;
  localparam logic [7:0] OFS_DATA   = 8'h20;
  localparam logic [7:0] OFS_RDREQ  = 8'h30;
  localparam logic [7:0] OFS_RDDATA = 8'h40;

  localparam int BUSY_BIT = 8;
  localparam int ERR_BIT  = 9;
  localparam int KEY_LSB  = 16;

  localparam int PROG_LSB  = 0;
  localparam int RELAX_LSB = 12;
  localparam int READ_LSB  = 16;

  typedef struct packed {
    logic startProg;
    logic startSense;
    logic finishProg;
    logic finishSense;
    logic raiseErr;
  } seq_strobe_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_RELAX_A,
    PH_STROBE,
    PH_RELAX_B
  } seq_phase_t;
endpackage

// File: rtl/fuse_seq_ctrl.sv
module fuse_seq_ctrl
  import fuse_seq_pkg::*;
#(
  parameter int PROG_W  = 12,
  parameter int RELAX_W = 4,
  parameter int READ_W  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrite,
  input  logic [7:0]         busAddr,
  input  logic               reqBit,
  input  logic               keyOk,
  input  logic [PROG_W-1:0]  progStrobe,
  input  logic [RELAX_W-1:0] relaxCount,
  input  logic [READ_W-1:0]  readStrobe,
  output seq_strobe_t        strb,
  output logic               busy
);
  localparam int MAX_RS = (RELAX_W > READ_W) ? RELAX_W : READ_W;
  localparam int CNT_W  = (PROG_W > MAX_RS) ? PROG_W : MAX_RS;

  seq_phase_t       phase;
  logic [CNT_W-1:0] cnt;
  logic             opIsProg;
  logic             progReq;
  logic             senseReq;
  logic             lastCycle;
  logic [CNT_W-1:0] relaxLoad;
  logic [CNT_W-1:0] strobeLen;

  assign progReq   = busWrite && (busAddr == OFS_DATA);
  assign senseReq  = busWrite && (busAddr == OFS_RDREQ) && reqBit;
  assign busy      = (phase != PH_IDLE);
  assign lastCycle = (phase == PH_RELAX_B) && (cnt == '0);
  assign relaxLoad = CNT_W'(relaxCount);
  assign strobeLen = opIsProg ? CNT_W'(progStrobe) : CNT_W'(readStrobe);

  always_comb begin
    strb.startProg   = !busy && progReq && keyOk;
    strb.startSense  = !busy && senseReq;
    strb.finishProg  = lastCycle && opIsProg;
    strb.finishSense = lastCycle && !opIsProg;
    strb.raiseErr    = (busy && (progReq || senseReq)) || (!busy && progReq && !keyOk);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      opIsProg <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (strb.startProg || strb.startSense) begin
            phase    <= PH_RELAX_A;
            cnt      <= relaxLoad;
            opIsProg <= strb.startProg;
          end
        end
        PH_RELAX_A: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (strobeLen == '0) begin
            phase <= PH_RELAX_B;
            cnt   <= relaxLoad;
          end else begin
            phase <= PH_STROBE;
            cnt   <= strobeLen - 1'b1;
          end
        end
        PH_STROBE: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            phase <= PH_RELAX_B;
            cnt   <= relaxLoad;
          end
        end
        default: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else phase <= PH_IDLE;
        end
      endcase
    end
  end

  AST_NOKEY_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && progReq && !keyOk) |=> !busy); // R4

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastCycle) |=> busy); // R3

  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    lastCycle |=> !busy); // R3
endmodule

// File: rtl/fuse_seq_datapath.sv
module fuse_seq_datapath
  import fuse_seq_pkg::*;
#(
  parameter int BANKS          = 4,
  parameter int WORDS_PER_BANK = 8,
  parameter int PROG_W         = 12,
  parameter int RELAX_W        = 4,
  parameter int READ_W         = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrite,
  input  logic [7:0]         busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  seq_strobe_t        strb,
  input  logic               busy,
  output logic               keyOk,
  output logic [PROG_W-1:0]  progStrobe,
  output logic [RELAX_W-1:0] relaxCount,
  output logic [READ_W-1:0]  readStrobe
);
  localparam int NUM_WORDS = BANKS * WORDS_PER_BANK;
  localparam int ADDR_W    = $clog2(NUM_WORDS);

  logic [15:0]       unlockKey;
  logic [15:0]       keyBase;
  logic [ADDR_W-1:0] addrField;
  logic [ADDR_W-1:0] opAddr;
  logic              errFlag;
  logic [31:0]       dataReg;
  logic [31:0]       readData;
  logic [31:0]       fuseMem [NUM_WORDS];
  logic [31:0]       curWord;
  logic [31:0]       ctrlView;
  logic [31:0]       timingView;
  logic              ctrlWr;
  logic              setWr;
  logic              clrWr;
  logic              timWr;

  assign ctrlWr  = busWrite && (busAddr == OFS_CTRL);
  assign setWr   = busWrite && (busAddr == OFS_SET);
  assign clrWr   = busWrite && (busAddr == OFS_CLR);
  assign timWr   = busWrite && (busAddr == OFS_TIMING);
  assign keyOk   = (unlockKey == UNLOCK_KEY);
  assign keyBase = strb.finishProg ? 16'h0 : unlockKey;
  assign curWord = fuseMem[opAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WORDS; i++) fuseMem[i] <= '0;
    end else if (strb.finishProg) begin
      fuseMem[opAddr] <= fuseMem[opAddr] | dataReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlockKey  <= '0;
      addrField  <= '0;
      errFlag    <= 1'b0;
      dataReg    <= '0;
      readData   <= '0;
      opAddr     <= '0;
      progStrobe <= PROG_W'(8);
      relaxCount <= RELAX_W'(1);
      readStrobe <= READ_W'(4);
    end else begin
      unlockKey <= keyBase;
      if (strb.finishSense) readData <= curWord;
      if (strb.startProg) begin
        dataReg <= busWdata;
        opAddr  <= addrField;
      end
      if (strb.startSense) opAddr <= addrField;
      if (strb.raiseErr) errFlag <= 1'b1;
      if (ctrlWr) begin
        unlockKey <= busWdata[KEY_LSB +: 16];
        addrField <= busWdata[ADDR_W-1:0];
      end
      if (setWr) begin
        unlockKey <= keyBase | busWdata[KEY_LSB +: 16];
        addrField <= addrField | busWdata[ADDR_W-1:0];
        if (busWdata[ERR_BIT]) errFlag <= 1'b1;
      end
      if (clrWr) begin
        unlockKey <= keyBase & ~busWdata[KEY_LSB +: 16];
        addrField <= addrField & ~busWdata[ADDR_W-1:0];
        if (busWdata[ERR_BIT]) errFlag <= 1'b0;
      end
      if (timWr) begin
        progStrobe <= busWdata[PROG_LSB +: PROG_W];
        relaxCount <= busWdata[RELAX_LSB +: RELAX_W];
        readStrobe <= busWdata[READ_LSB +: READ_W];
      end
    end
  end

  always_comb begin
    ctrlView                   = '0;
    ctrlView[KEY_LSB +: 16]    = unlockKey;
    ctrlView[ERR_BIT]          = errFlag;
    ctrlView[BUSY_BIT]         = busy;
    ctrlView[ADDR_W-1:0]       = addrField;
    timingView                 = '0;
    timingView[PROG_LSB +: PROG_W]   = progStrobe;
    timingView[RELAX_LSB +: RELAX_W] = relaxCount;
    timingView[READ_LSB +: READ_W]   = readStrobe;
    unique case (busAddr)
      OFS_CTRL, OFS_SET, OFS_CLR: busRdata = ctrlView;
      OFS_TIMING:                 busRdata = timingView;
      OFS_DATA:                   busRdata = dataReg;
      OFS_RDDATA:                 busRdata = readData;
      default:                    busRdata = '0;
    endcase
  end

  AST_KEY_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finishProg && !ctrlWr && !setWr) |=> (unlockKey == 16'h0)); // R6

  AST_FUSE_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    strb.finishProg |=> ((curWord & $past(curWord)) == $past(curWord))); // R8

  AST_ERR_ON_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    strb.raiseErr |=> errFlag); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !(clrWr && busWdata[ERR_BIT])) |=> errFlag); // R10
endmodule

// File: rtl/fuse_sequencer.sv
module fuse_sequencer
  import fuse_seq_pkg::*;
#(
  parameter int BANKS          = 4,
  parameter int WORDS_PER_BANK = 8,
  parameter int PROG_W         = 12,
  parameter int RELAX_W        = 4,
  parameter int READ_W         = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrite,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata
);
  seq_strobe_t        strb;
  logic               busy;
  logic               keyOk;
  logic [PROG_W-1:0]  progStrobe;
  logic [RELAX_W-1:0] relaxCount;
  logic [READ_W-1:0]  readStrobe;

  fuse_seq_ctrl #(
    .PROG_W(PROG_W), .RELAX_W(RELAX_W), .READ_W(READ_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .reqBit(busWdata[0]), .keyOk(keyOk), .progStrobe(progStrobe),
    .relaxCount(relaxCount), .readStrobe(readStrobe), .strb(strb), .busy(busy)
  );

  fuse_seq_datapath #(
    .BANKS(BANKS), .WORDS_PER_BANK(WORDS_PER_BANK),
    .PROG_W(PROG_W), .RELAX_W(RELAX_W), .READ_W(READ_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .strb(strb), .busy(busy),
    .keyOk(keyOk), .progStrobe(progStrobe), .relaxCount(relaxCount),
    .readStrobe(readStrobe)
  );
endmodule

// File: tb/test_fuse_sequencer.sv
`timescale 1ns/1ps
module test_fuse_sequencer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;

  int vectors = 0;
  int misses  = 0;

  int unsigned fuse [32];
  int unsigned mKey, mAddr, mErr, mProg, mRelax, mRead, mData, mRd;
  int unsigned mOpAddr, mOpProg, busyCnt;

  always #2.5 clk = ~clk;

  fuse_sequencer i_fuse_sequencer (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata)
  );

  function automatic logic [31:0] expRead(logic [7:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      8'h00, 8'h04, 8'h08: begin
        v[31:16] = mKey[15:0];
        v[9] = mErr[0];
        v[8] = (busyCnt > 0);
        v[4:0] = mAddr[4:0];
      end
      8'h10: v = (mRead << 16) | (mRelax << 12) | mProg;
      8'h20: v = mData;
      8'h40: v = mRd;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic modelEdge(bit we, logic [7:0] a, logic [31:0] d);
    bit wasBusy;
    wasBusy = (busyCnt > 0);
    if (wasBusy) begin
      busyCnt--;
      if (busyCnt == 0) begin
        if (mOpProg != 0) begin
          fuse[mOpAddr] = fuse[mOpAddr] | mData;
          mKey = 0;
        end else begin
          mRd = fuse[mOpAddr];
        end
      end
    end
    if (we) begin
      case (a)
        8'h00: begin mKey = d[31:16]; mAddr = d[4:0]; end
        8'h04: begin mKey |= d[31:16]; mAddr |= d[4:0]; if (d[9]) mErr = 1; end
        8'h08: begin mKey &= ~d[31:16] & 32'hFFFF; mAddr &= ~d[4:0] & 32'h1F; if (d[9]) mErr = 0; end
        8'h10: begin mProg = d[11:0]; mRelax = d[15:12]; mRead = d[21:16]; end
        8'h20: begin
          if (wasBusy || mKey != 32'h3E77) mErr = 1;
          else begin
            mData = d; mOpAddr = mAddr; mOpProg = 1;
            busyCnt = 2 * (mRelax + 1) + mProg;
          end
        end
        8'h30: if (d[0]) begin
          if (wasBusy) mErr = 1;
          else begin
            mOpAddr = mAddr; mOpProg = 0;
            busyCnt = 2 * (mRelax + 1) + mRead;
          end
        end
        default: ;
      endcase
    end
  endtask

  task automatic compare(string tag);
    logic [31:0] e;
    e = expRead(busAddr);
    vectors++;
    if (busRdata !== e) begin
      misses++;
      $display("FAIL %s addr=%02h actual=%08h expected=%08h", tag, busAddr, busRdata, e);
    end
  endtask

  task automatic cyc(bit we, logic [7:0] a, logic [31:0] d, string tag);
    busWrite = we; busAddr = a; busWdata = d;
    @(posedge clk);
    modelEdge(we, a, d);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(int n, logic [7:0] a, string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, a, 32'h0, tag);
  endtask

  task automatic waitDone(string tag);
    while (busyCnt > 0) cyc(1'b0, 8'h00, 32'h0, tag);
  endtask

  initial begin
    #400000;
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) fuse[i] = 0;
    mKey = 0; mAddr = 0; mErr = 0; mProg = 8; mRelax = 1; mRead = 4;
    mData = 0; mRd = 0; mOpAddr = 0; mOpProg = 0; busyCnt = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values at several offsets
    idle(1, 8'h00, "R1"); idle(1, 8'h10, "R1"); idle(1, 8'h40, "R1"); idle(1, 8'h50, "R1");

    // R4 program without key
    cyc(1'b1, 8'h00, 32'h1234_0005, "R2");
    cyc(1'b1, 8'h20, 32'hFFFF_FFFF, "R4");
    idle(4, 8'h00, "R4");
    // R10 direct write cannot clear error; clear alias does
    cyc(1'b1, 8'h00, 32'h0000_0000, "R10");
    idle(1, 8'h00, "R10");
    cyc(1'b1, 8'h08, 32'h0000_0200, "R10");
    idle(1, 8'h08, "R10");
    // R4 confirm nothing burned: sense word 5
    cyc(1'b1, 8'h00, 32'h0000_0005, "R2");
    cyc(1'b1, 8'h30, 32'h1, "R7");
    waitDone("R3");
    idle(1, 8'h40, "R4");

    // R3 timing register, R2 address bank 2 word 3 = 19
    cyc(1'b1, 8'h10, 32'hFFC3_1005, "R3");
    idle(1, 8'h10, "R3");
    cyc(1'b1, 8'h00, 32'h3E77_0013, "R2");
    cyc(1'b1, 8'h20, 32'h0000_00F0, "R5");
    idle(2, 8'h00, "R3");
    cyc(1'b1, 8'h20, 32'hAAAA_AAAA, "R9");
    cyc(1'b1, 8'h30, 32'h1, "R9");
    waitDone("R3");
    idle(1, 8'h20, "R5"); idle(1, 8'h00, "R6");
    cyc(1'b1, 8'h08, 32'h0000_0200, "R10");
    cyc(1'b1, 8'h30, 32'h0, "R7");
    idle(2, 8'h00, "R7");
    cyc(1'b1, 8'h30, 32'h1, "R7");
    waitDone("R7");
    idle(1, 8'h40, "R7");

    // R8 second program on same word; R6 key needed again
    cyc(1'b1, 8'h20, 32'h0F00_000F, "R6");
    idle(1, 8'h00, "R6");
    cyc(1'b1, 8'h08, 32'h0000_0200, "R10");
    cyc(1'b1, 8'h04, 32'h3E77_0000, "R10");
    cyc(1'b1, 8'h20, 32'h0F00_000F, "R8");
    waitDone("R8");
    cyc(1'b1, 8'h20, 32'h3E77_0000, "R4");
    cyc(1'b1, 8'h08, 32'h0000_0200, "R10");
    cyc(1'b1, 8'h30, 32'h1, "R8");
    waitDone("R8");
    idle(1, 8'h40, "R8");

    // R9 request on the final busy cycle
    cyc(1'b1, 8'h30, 32'h1, "R7");
    while (busyCnt > 1) cyc(1'b0, 8'h00, 32'h0, "R3");
    cyc(1'b1, 8'h30, 32'h1, "R9");
    idle(3, 8'h00, "R9");
    cyc(1'b1, 8'h08, 32'h0000_0200, "R10");

    // R3 zero relax and zero strobe, program bank 0 word 0
    cyc(1'b1, 8'h10, 32'h0000_0000, "R3");
    cyc(1'b1, 8'h00, 32'h3E77_0000, "R2");
    cyc(1'b1, 8'h20, 32'h8000_0001, "R5");
    idle(4, 8'h00, "R3");
    cyc(1'b1, 8'h30, 32'h1, "R7");
    idle(3, 8'h40, "R7");

    // R10 alias on address bits
    cyc(1'b1, 8'h04, 32'h0000_0015, "R10");
    cyc(1'b1, 8'h08, 32'h0000_0004, "R10");
    cyc(1'b1, 8'h04, 32'h0000_0200, "R10");
    idle(1, 8'h04, "R10");
    cyc(1'b1, 8'h08, 32'h0000_0200, "R10");

    // R3 largest relax and sense strobe on word 17
    cyc(1'b1, 8'h10, 32'h003F_F001, "R3");
    cyc(1'b1, 8'h30, 32'h1, "R3");
    waitDone("R3");
    idle(2, 8'h40, "R7");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule